// File: doc/BRIEF.md
# CAN Operating-State and Bus-Off Recovery Sequencer

This block decides when a CAN protocol controller may take part in bus traffic. It holds the controller in an initialization state after hardware reset or a software request. When software releases it, the block watches the received bus level for an idle period before it enables participation. It keeps the transmit and receive error counters. When either counter reaches the bus-off threshold, the block isolates the node. Once software releases the node again, the block runs a long recovery before traffic resumes.

The protocol engine supplies a sampled-bit strobe with the received level, error-counter step requests, and error codes. Software controls one bit, which requests initialization. The block reports the participation enable, an isolate flag, the initialization and bus-off flags, a 3-bit last-error-code field, and both error counters.

Top module: `can_opstate_seq`

## Requirements
- R1: After a synchronous active-low reset, init_o=1, busoff_o=0, isolate_o=0, bus_en_o=0, lec_o=0, tec_o=0 and rec_o=0.
- R2: A write with cfg_wr_i=1 and cfg_init_i=1 sets init_o on the next edge from any state, and drops bus_en_o.
- R3: While init_o=1, error-counter step requests are ignored, so tec_o and rec_o keep their values. bus_en_o stays 0.
- R4: After software clears init with busoff_o=0, bus_en_o rises on the edge of the 11th consecutive recessive strobed bit (rx=1). A strobed dominant bit (rx=0) restarts the run from zero.
- R5: Once tec_o or rec_o is at or above 256, the next edge sets busoff_o, isolate_o and init_o, and clears bus_en_o.
- R6: In normal operation an increment request adds 1, or adds 8 when inc_by8_i=1. A decrement request subtracts 1 and stops at 0. The counters are 9 bits wide and saturate at 511.
- R7: Bus-off recovery begins only when software clears init while busoff_o=1. It needs 128 separate runs of 11 consecutive recessive bits. A dominant bit restarts only the current run, not the count of completed runs.
- R8: During recovery, every strobed recessive bit writes code 5 (bit-0 error) into lec_o. A strobed dominant bit leaves lec_o unchanged.
- R9: The edge that completes the 128th run clears busoff_o and isolate_o, zeroes both counters and raises bus_en_o.
- R10: A software set of init during recovery aborts the recovery and keeps busoff_o=1. This holds even in the cycle in which recovery would have completed. The next recovery needs a full 128 runs.
- R11: In normal operation a strobe with err_code_vld_i=1 loads err_code_i into lec_o. The codes are 0 none, 1 stuff, 2 form, 3 acknowledge, 4 bit-1, 5 bit-0 and 6 CRC. Without a strobe, lec_o holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_strobe_i | input | 1 | One-cycle pulse per sampled bus bit |
| rx_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| tec_inc_i | input | 1 | Transmit error counter increment request |
| tec_dec_i | input | 1 | Transmit error counter decrement request |
| rec_inc_i | input | 1 | Receive error counter increment request |
| rec_dec_i | input | 1 | Receive error counter decrement request |
| inc_by8_i | input | 1 | Increment step is 8 instead of 1 |
| err_code_vld_i | input | 1 | Error code present for this bit |
| err_code_i | input | 3 | Error code from the protocol engine |
| cfg_wr_i | input | 1 | Software write strobe for the init bit |
| cfg_init_i | input | 1 | Value written to the init bit |
| bus_en_o | output | 1 | Node may take part in bus traffic |
| isolate_o | output | 1 | Node is cut off from the bus (bus-off) |
| init_o | output | 1 | Initialization state flag |
| busoff_o | output | 1 | Bus-off flag |
| lec_o | output | 3 | Last error code |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 9 | Receive error counter |

## Verification
Two events can fall on the same clock edge: the strobed recessive bit that finishes the 128th idle run, and a software write that sets init. The bench provokes this by driving the write in the same cycle as the final recovery bit. The abort must win: init_o must read 1 and busoff_o must stay 1. A full 128-run recovery that follows must then still be needed before traffic resumes. The idle-run restart is swept for every dominant position from 0 to 10 before the 11th recessive bit.

// File: rtl/can_seq_pkg.sv
// Package: shared state encoding and last-error-code values for the
// CAN operating-state sequencer. Assumes a 3-bit error code field.
package can_seq_pkg;
    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_RUN   = 2'd2,
        ST_RECOV = 2'd3
    } opstate_e;

    localparam logic [2:0] LEC_NONE  = 3'd0;
    localparam logic [2:0] LEC_STUFF = 3'd1;
    localparam logic [2:0] LEC_FORM  = 3'd2;
    localparam logic [2:0] LEC_ACK   = 3'd3;
    localparam logic [2:0] LEC_BIT1  = 3'd4;
    localparam logic [2:0] LEC_BIT0  = 3'd5;
    localparam logic [2:0] LEC_CRC   = 3'd6;
endpackage

// File: rtl/can_err_cnt.sv
// Module: one saturating error counter.
// Increments by 1 or 8 and decrements by 1, with a floor of 0 and a
// ceiling of 2**W-1. It updates only while en is high. A clear takes
// priority over everything else.
// Assumes the requests are single-cycle pulses from the protocol engine.
module can_err_cnt #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         inc,
    input  logic         step8,
    input  logic         dec,
    input  logic         clr,
    output logic [W-1:0] cnt_o
);
    localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nxt;
    logic [W:0]   sum;

    // Next counter value: add the step, take one off, then clamp.
    always_comb begin
        sum = {1'b0, cnt_q};
        if (inc) begin
            sum = sum + (step8 ? (W+1)'(8) : (W+1)'(1));
        end
        if (dec && (sum != '0)) begin
            sum = sum - (W+1)'(1);
        end
        if (sum > MAXV) begin
            cnt_nxt = MAXV[W-1:0];
        end else begin
            cnt_nxt = sum[W-1:0];
        end
    end

    // Counter register with synchronous reset and clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_nxt;
        end
    end

    assign cnt_o = cnt_q;

    // R3: the value is frozen while counting is disabled.
    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt_q));

    // R6: a plain decrement above zero lowers the value by exactly one.
    assert_dec_by_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !inc && dec && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/can_idle_det.sv
// Module: bus-idle detector and idle-run counter.
// It counts consecutive recessive strobed bits. The strobe that
// completes IDLE_BITS of them raises idle_hit and restarts the run.
// It also counts completed runs while occ_en is high, and raises
// occ_done on the run that makes OCC_MAX.
// Assumes that dropping run_en or occ_en clears the matching counter.
module can_idle_det #(
    parameter int IDLE_BITS = 11,
    parameter int OCC_MAX   = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic occ_en,
    input  logic strobe,
    input  logic rx,
    output logic idle_hit,
    output logic occ_done
);
    localparam int RUN_W = $clog2(IDLE_BITS + 1);
    localparam int OCC_W = $clog2(OCC_MAX + 1);

    logic [RUN_W-1:0] run_q;
    logic [OCC_W-1:0] occ_q;

    assign idle_hit = run_en && strobe && rx && (run_q == RUN_W'(IDLE_BITS - 1));
    assign occ_done = occ_en && idle_hit && (occ_q == OCC_W'(OCC_MAX - 1));

    // Consecutive-recessive run counter; a dominant bit restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            run_q <= '0;
        end else if (strobe) begin
            if (!rx || idle_hit) begin
                run_q <= '0;
            end else begin
                run_q <= run_q + RUN_W'(1);
            end
        end
    end

    // Completed-run counter; dominant bits leave it alone.
    always_ff @(posedge clk) begin
        if (!rst_n || !occ_en || occ_done) begin
            occ_q <= '0;
        end else if (idle_hit) begin
            occ_q <= occ_q + OCC_W'(1);
        end
    end

    // R4: a dominant bit restarts the run.
    assert_dominant_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !rx) |=> (run_q == '0));

    // R7: a dominant bit does not disturb the completed-run count.
    assert_occ_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_en && strobe && !rx) |=> $stable(occ_q));
endmodule

// File: rtl/can_lec_unit.sv
// Module: last-error-code register.
// During recovery, each strobed recessive bit writes the bit-0 code.
// In normal operation, a strobed bit with a valid code loads that code.
// Assumes the field changes only on a sampled-bit strobe.
module can_lec_unit
    import can_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe,
    input  logic       rx,
    input  logic       recov,
    input  logic       run,
    input  logic       code_vld,
    input  logic [2:0] code,
    output logic [2:0] lec_o
);
    logic [2:0] lec_q;

    // Field update on strobed bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lec_q <= LEC_NONE;
        end else if (strobe) begin
            if (recov && rx) begin
                lec_q <= LEC_BIT0;
            end else if (run && code_vld) begin
                lec_q <= code;
            end
        end
    end

    assign lec_o = lec_q;

    // R8: a recessive bit during recovery leaves the bit-0 code.
    assert_recov_bit0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && recov && rx) |=> (lec_q == LEC_BIT0));

    // R11: without a strobe the field holds.
    assert_hold_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(lec_q));
endmodule

// File: rtl/can_opstate_seq.sv
// Module: CAN operating-state sequencer (top).
// It steps through initialization, idle sync, normal run, bus-off and
// bus-off recovery. It owns both error counters, the bus-off flag and
// the last-error-code field.
// Assumes a one-cycle bit strobe and single-cycle software writes.
// A software set of init always wins over same-cycle completion events.
module can_opstate_seq
    import can_seq_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int IDLE_BITS   = 11,
    parameter int RECOV_IDLES = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_strobe_i,
    input  logic             rx_bit_i,
    input  logic             tec_inc_i,
    input  logic             tec_dec_i,
    input  logic             rec_inc_i,
    input  logic             rec_dec_i,
    input  logic             inc_by8_i,
    input  logic             err_code_vld_i,
    input  logic [2:0]       err_code_i,
    input  logic             cfg_wr_i,
    input  logic             cfg_init_i,
    output logic             bus_en_o,
    output logic             isolate_o,
    output logic             init_o,
    output logic             busoff_o,
    output logic [2:0]       lec_o,
    output logic [CNT_W-1:0] tec_o,
    output logic [CNT_W-1:0] rec_o
);
    localparam logic [CNT_W-1:0] BO_LIMIT = {1'b1, {(CNT_W-1){1'b0}}};
    localparam int NCNT = 2;

    opstate_e state_q, state_nxt;
    logic     busoff_q;
    logic     set_bo, clr_bo;
    logic     sw_set, sw_clr;
    logic     over;
    logic     idle_hit, occ_done;
    logic     run_en, occ_en, cnt_en;

    logic [NCNT-1:0]            inc_v, dec_v;
    logic [NCNT-1:0][CNT_W-1:0] cnt_v;

    assign sw_set = cfg_wr_i && cfg_init_i;
    assign sw_clr = cfg_wr_i && !cfg_init_i;

    assign inc_v = {rec_inc_i, tec_inc_i};
    assign dec_v = {rec_dec_i, tec_dec_i};

    assign run_en = (state_q == ST_SYNC) || (state_q == ST_RECOV);
    assign occ_en = (state_q == ST_RECOV);
    assign cnt_en = (state_q == ST_RUN);

    // One counter per direction: index 0 transmit, index 1 receive.
    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        can_err_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (cnt_en),
            .inc   (inc_v[g]),
            .step8 (inc_by8_i),
            .dec   (dec_v[g]),
            .clr   (clr_bo),
            .cnt_o (cnt_v[g])
        );
    end

    assign tec_o = cnt_v[0];
    assign rec_o = cnt_v[1];
    assign over  = (cnt_v[0] >= BO_LIMIT) || (cnt_v[1] >= BO_LIMIT);

    can_idle_det #(
        .IDLE_BITS (IDLE_BITS),
        .OCC_MAX   (RECOV_IDLES)
    ) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .occ_en   (occ_en),
        .strobe   (bit_strobe_i),
        .rx       (rx_bit_i),
        .idle_hit (idle_hit),
        .occ_done (occ_done)
    );

    can_lec_unit u_lec (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (bit_strobe_i),
        .rx       (rx_bit_i),
        .recov    (occ_en),
        .run      (cnt_en),
        .code_vld (err_code_vld_i),
        .code     (err_code_i),
        .lec_o    (lec_o)
    );

    // Next-state decode; a software set of init outranks completion events.
    always_comb begin
        state_nxt = state_q;
        set_bo    = 1'b0;
        clr_bo    = 1'b0;
        unique case (state_q)
            ST_INIT: begin
                if (sw_clr) begin
                    state_nxt = busoff_q ? ST_RECOV : ST_SYNC;
                end
            end
            ST_SYNC: begin
                if (sw_set) begin
                    state_nxt = ST_INIT;
                end else if (idle_hit) begin
                    state_nxt = ST_RUN;
                end
            end
            ST_RUN: begin
                if (over) begin
                    state_nxt = ST_INIT;
                    set_bo    = 1'b1;
                end else if (sw_set) begin
                    state_nxt = ST_INIT;
                end
            end
            ST_RECOV: begin
                if (sw_set) begin
                    state_nxt = ST_INIT;
                end else if (occ_done) begin
                    state_nxt = ST_RUN;
                    clr_bo    = 1'b1;
                end
            end
            default: state_nxt = ST_INIT;
        endcase
    end

    // State register; reset enters initialization.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Bus-off flag: set on threshold, cleared only by finished recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busoff_q <= 1'b0;
        end else if (set_bo) begin
            busoff_q <= 1'b1;
        end else if (clr_bo) begin
            busoff_q <= 1'b0;
        end
    end

    assign bus_en_o  = (state_q == ST_RUN);
    assign init_o    = (state_q == ST_INIT);
    assign busoff_o  = busoff_q;
    assign isolate_o = busoff_q;

    // R2: a software set of init always lands in initialization.
    assert_sw_set_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set |=> (init_o && !bus_en_o));

    // R5: reaching the threshold in normal run enters bus-off with init set.
    assert_threshold_busoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && (tec_o >= BO_LIMIT)) |=> (busoff_o && init_o));

    // R9: leaving bus-off comes with zeroed counters and bus participation.
    assert_exit_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busoff_q) |-> ((tec_o == '0) && (rec_o == '0) && bus_en_o));

    // R10: an abort during recovery keeps bus-off set.
    assert_abort_keeps_busoff_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RECOV) && sw_set) |=> (busoff_o && init_o));
endmodule

// File: tb/can_opstate_seq_tb_top.sv
module can_opstate_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_strobe = 1'b0, rx_bit = 1'b1;
    logic       tec_inc = 1'b0, tec_dec = 1'b0, rec_inc = 1'b0, rec_dec = 1'b0, by8 = 1'b0;
    logic       code_vld = 1'b0;
    logic [2:0] code = 3'd0;
    logic       cfg_wr = 1'b0, cfg_init = 1'b0;
    logic       bus_en, isolate, init, busoff;
    logic [2:0] lec;
    logic [8:0] tec, rec;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    can_opstate_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bit_strobe_i(bit_strobe), .rx_bit_i(rx_bit),
        .tec_inc_i(tec_inc), .tec_dec_i(tec_dec), .rec_inc_i(rec_inc), .rec_dec_i(rec_dec),
        .inc_by8_i(by8), .err_code_vld_i(code_vld), .err_code_i(code),
        .cfg_wr_i(cfg_wr), .cfg_init_i(cfg_init), .bus_en_o(bus_en), .isolate_o(isolate),
        .init_o(init), .busoff_o(busoff), .lec_o(lec), .tec_o(tec), .rec_o(rec)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        bit_strobe = 1'b1; rx_bit = b;
        @(negedge clk);
        bit_strobe = 1'b0; rx_bit = 1'b1;
    endtask

    task automatic bit_with_write(input logic b, input logic v);
        bit_strobe = 1'b1; rx_bit = b; cfg_wr = 1'b1; cfg_init = v;
        @(negedge clk);
        bit_strobe = 1'b0; rx_bit = 1'b1; cfg_wr = 1'b0;
    endtask

    task automatic write_init(input logic v);
        cfg_wr = 1'b1; cfg_init = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse(input logic ti, input logic td, input logic ri, input logic rd, input logic s8);
        tec_inc = ti; tec_dec = td; rec_inc = ri; rec_dec = rd; by8 = s8;
        @(negedge clk);
        tec_inc = 1'b0; tec_dec = 1'b0; rec_inc = 1'b0; rec_dec = 1'b0; by8 = 1'b0;
    endtask

    task automatic idles(input int n);
        for (int i = 0; i < n; i++) begin
            repeat (11) send_bit(1'b1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 init", init, 1); chk("R1 busoff", busoff, 0); chk("R1 isolate", isolate, 0);
        chk("R1 bus_en", bus_en, 0); chk("R1 lec", lec, 0); chk("R1 tec", tec, 0); chk("R1 rec", rec, 0);

        // R3 step requests ignored while init
        pulse(1, 0, 1, 0, 1);
        chk("R3 tec held", tec, 0); chk("R3 rec held", rec, 0);

        // R4 sweep of dominant position before idle
        write_init(0);
        chk("R4 left init", init, 0);
        for (int k = 0; k <= 10; k++) begin
            repeat (k) send_bit(1'b1);
            send_bit(1'b0);
            chk("R4 no enable after dominant", bus_en, 0);
        end
        repeat (10) send_bit(1'b1);
        chk("R4 ten recessive", bus_en, 0);
        send_bit(1'b1);
        chk("R4 eleventh recessive", bus_en, 1);

        // R6 counter arithmetic
        pulse(0, 1, 0, 1, 0);
        chk("R6 floor tec", tec, 0); chk("R6 floor rec", rec, 0);
        pulse(1, 0, 0, 0, 0); pulse(1, 0, 0, 0, 0); pulse(1, 0, 0, 0, 0);
        chk("R6 inc by one", tec, 3);
        pulse(1, 0, 0, 0, 1);
        chk("R6 inc by eight", tec, 11);
        pulse(1, 1, 0, 0, 0);
        chk("R6 inc and dec", tec, 11);
        pulse(0, 1, 0, 0, 0);
        chk("R6 dec", tec, 10);
        for (int i = 1; i <= 20; i++) begin
            pulse(0, 0, 1, 0, 0);
            chk("R6 rec sweep", rec, i);
        end

        // R2 software set during run, R3 hold in init
        write_init(1);
        chk("R2 init set", init, 1); chk("R2 bus off", bus_en, 0);
        pulse(1, 0, 0, 1, 0);
        chk("R3 tec kept", tec, 10); chk("R3 rec kept", rec, 20);
        write_init(0);
        idles(1);
        chk("R4 back to run", bus_en, 1);

        // R11 error codes
        for (int c = 1; c <= 6; c++) begin
            bit_strobe = 1'b1; rx_bit = 1'b0; code_vld = 1'b1; code = 3'(c);
            @(negedge clk);
            bit_strobe = 1'b0; code_vld = 1'b0;
            chk("R11 code load", lec, c);
        end
        code_vld = 1'b1; code = 3'd3;
        @(negedge clk);
        code_vld = 1'b0;
        chk("R11 no strobe hold", lec, 6);
        bit_strobe = 1'b1; rx_bit = 1'b0; code_vld = 1'b1; code = 3'd2;
        @(negedge clk);
        bit_strobe = 1'b0; code_vld = 1'b0;
        chk("R11 form code", lec, 2);

        // R5 transmit counter to bus-off
        exp = 10;
        while (exp < 256) begin
            pulse(1, 0, 0, 0, 1);
            exp = (exp + 8 > 511) ? 511 : exp + 8;
            chk("R6 step8 climb", tec, exp);
        end
        chk("R5 not yet", busoff, 0);
        @(negedge clk);
        chk("R5 busoff", busoff, 1); chk("R5 isolate", isolate, 1);
        chk("R5 init", init, 1); chk("R5 bus_en", bus_en, 0);

        // R7 no recovery while init held
        repeat (22) send_bit(1'b1);
        chk("R7 held busoff", busoff, 1); chk("R8 lec untouched in init", lec, 2);

        // R8 recovery codes
        write_init(0);
        send_bit(1'b0);
        chk("R8 dominant keeps lec", lec, 2);
        send_bit(1'b1);
        chk("R8 recessive bit0", lec, 5);
        repeat (10) send_bit(1'b1);
        idles(49);
        // R10 abort after 50 runs
        write_init(1);
        chk("R10 abort init", init, 1); chk("R10 abort busoff", busoff, 1);
        write_init(0);
        // R7 dominant inside a run does not lose completed runs
        idles(59);
        repeat (7) send_bit(1'b1);
        send_bit(1'b0);
        idles(68);
        repeat (10) send_bit(1'b1);
        chk("R7 127 runs", busoff, 1);
        // R10 write in the completing cycle wins
        bit_with_write(1'b1, 1'b1);
        chk("R10 coincident init", init, 1); chk("R10 coincident busoff", busoff, 1);
        chk("R10 coincident bus_en", bus_en, 0);
        write_init(0);
        idles(127);
        repeat (10) send_bit(1'b1);
        chk("R7 full count needed", busoff, 1); chk("R7 still isolated", bus_en, 0);
        send_bit(1'b1);
        chk("R9 busoff cleared", busoff, 0); chk("R9 isolate cleared", isolate, 0);
        chk("R9 bus_en", bus_en, 1); chk("R9 tec zero", tec, 0); chk("R9 rec zero", rec, 0);
        chk("R9 init clear", init, 0);

        // R5 receive counter to bus-off
        for (int i = 1; i <= 32; i++) begin
            pulse(0, 0, 1, 0, 1);
        end
        chk("R5 rec at limit", rec, 256);
        @(negedge clk);
        chk("R5 rec busoff", busoff, 1); chk("R5 rec isolate", isolate, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule